// File: doc/BRIEF.md
# Dual-Compare Timer Output Controller

This block is an up-counting timer with two compare registers, A and B. Both registers drive one shared timer output pin. A separate 2-bit action field for each register sets what happens to the pin when that register matches the counter. The four actions are hold, drive low, drive high and toggle. When both registers match in the same cycle, a fixed ranking picks one action. Toggle ranks above drive high, drive high ranks above drive low, and drive low ranks above hold.

Setting a capture-enable bit changes the role of register B. It stops acting as a compare register and instead latches the counter value when an edge arrives on a synchronized capture pin. In that mode, register B's 2-bit action field selects which edge triggers the capture.

Three sticky flags record events: a compare-A match, a compare-B match and a capture. Each flag stays set until a 1 is written to its clear bit. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `dual_cmp_timer`

## Requirements
- R1: The counter resets to 0. It increments by one on each clock with `cnt_en` high and holds while `cnt_en` is low. It wraps from 2^W-1 to 0.
- R2: A compare-A match is the cycle in which `cnt_en` is high and the counter equals register A. The pin changes at the following clock edge according to `ctrl_wdata[1:0]`: 00 hold, 01 drive 0, 10 drive 1, 11 toggle.
- R3: A compare-B match works the same way using `ctrl_wdata[3:2]`, with the same encoding, while capture mode is off.
- R4: When A and B match in the same cycle, the pin takes the higher-ranked action. The ranking is toggle over drive 1, drive 1 over drive 0, and drive 0 over hold.
- R5: While all four action bits (`ctrl_wdata[3:0]` as last written) are 0, the pin drives 0.
- R6: Reset clears the counter, both compare registers, the control bits, the flags and the pin to 0.
- R7: With `ctrl_wdata[4]` (capture enable) set, register B loads the counter value on a capture-pin edge and sets the capture flag. The edge is selected by `ctrl_wdata[3:2]`: 00 rising only, 01 falling only, 1x both. The pin passes through a two-flop synchronizer before edge detection.
- R8: In capture mode, register B produces no compare match. The B flag stays clear, and register B's action does not reach the pin.
- R9: `flags[0]` (A match), `flags[1]` (B match) and `flags[2]` (capture) are sticky. Each is cleared by a 1 on the matching `flag_clr` bit. A new set event in the same cycle wins over the clear.
- R10: Between matches, the pin holds its last level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| cmpa_wr | input | 1 | Write `reg_wdata` to register A |
| cmpb_wr | input | 1 | Write `reg_wdata` to register B |
| reg_wdata | input | W | Compare register write data |
| ctrl_wr | input | 1 | Write `ctrl_wdata` to the control bits |
| ctrl_wdata | input | 5 | [1:0] A action, [3:2] B action or edge select, [4] capture enable |
| flag_clr | input | 3 | Write-1-to-clear for the flags |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer output pin |
| flags | output | 3 | Sticky flags: A match, B match, capture |
| count_o | output | W | Current counter value |
| regb_o | output | W | Register B contents (compare value or captured value) |

## Verification
The bench builds the block with the defaults W=8 and two synchronizer stages. With W=8, a full counter wrap takes 256 cycles, so the bench can return to the same compare point once per priority pairing. Each pairing then starts from a known pin level, which makes the outcomes of toggle, drive 1, drive 0 and hold distinguishable. Capture tests freeze the counter so that the latched value can be predicted whatever the synchronizer latency. The three edge selections are exercised in turn on the same pin sequence.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic     cap_en;
    pin_act_e sel_b;
    pin_act_e sel_a;
  } tmr_ctrl_t;

  localparam int CTRL_W = 5;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_A = 0;
  localparam int FLG_B = 1;
  localparam int FLG_CAP = 2;

  // Encoding order equals priority order, so the larger code wins.
  function automatic pin_act_e act_rank(input pin_act_e a, input pin_act_e b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q == CNT_MAX) |=> (cnt_q == '0)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic       mode_en,
  input  logic [1:0] edge_sel,
  output logic       evt
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            rise, fall;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC-1];
  end

  assign rise = sync_q[SYNC-1] & ~prev_q;
  assign fall = ~sync_q[SYNC-1] & prev_q;

  always_comb begin
    evt = 1'b0;
    if (mode_en) begin
      unique casez (edge_sel)
        2'b00:   evt = rise;
        2'b01:   evt = fall;
        default: evt = rise | fall;
      endcase
    end
  end

  AST_CAP_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    evt |-> (sync_q[SYNC-1] != prev_q)); // R7
endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     out_en,
  input  pin_act_e act_a,
  input  pin_act_e act_b,
  output logic     pin_o
);
  pin_act_e win;
  logic     pin_q;
  logic     pin_d;

  assign win = act_rank(act_a, act_b);

  always_comb begin
    pin_d = pin_q;
    unique case (win)
      ACT_HOLD:   pin_d = pin_q;
      ACT_LOW:    pin_d = 1'b0;
      ACT_HIGH:   pin_d = 1'b1;
      ACT_TOGGLE: pin_d = ~pin_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          pin_q <= 1'b0;
    else if (!out_en) pin_q <= 1'b0;
    else              pin_q <= pin_d;
  end

  assign pin_o = out_en & pin_q;

  AST_TOGGLE_WINS: assert property (@(posedge clk) disable iff (rst)
    (out_en && (act_a == ACT_TOGGLE || act_b == ACT_TOGGLE)) |=> (pin_q != $past(pin_q))); // R4
  AST_HIGH_OVER_LOW: assert property (@(posedge clk) disable iff (rst)
    (out_en && act_a != ACT_TOGGLE && act_b != ACT_TOGGLE &&
     (act_a == ACT_HIGH || act_b == ACT_HIGH)) |=> pin_q); // R4
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_en && act_a == ACT_HOLD && act_b == ACT_HOLD) |=> $stable(pin_q)); // R10
  AST_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !pin_q); // R5
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_en,
  input  logic                  cmpa_wr,
  input  logic                  cmpb_wr,
  input  logic [W-1:0]          reg_wdata,
  input  logic                  ctrl_wr,
  input  logic [CTRL_W-1:0]     ctrl_wdata,
  input  logic [NUM_FLAGS-1:0]  flag_clr,
  input  logic                  cap_pin,
  output logic                  tmr_out,
  output logic [NUM_FLAGS-1:0]  flags,
  output logic [W-1:0]          count_o,
  output logic [W-1:0]          regb_o
);
  localparam int NCMP = 2;

  tmr_ctrl_t              ctrl_q;
  logic [W-1:0]           cnt;
  logic [W-1:0]           cmp_q [NCMP];
  logic [NCMP-1:0]        cmp_gate;
  logic [NCMP-1:0]        match;
  logic                   cap_evt;
  logic                   out_en;
  logic [NUM_FLAGS-1:0]   flag_q;
  logic [NUM_FLAGS-1:0]   flag_set;
  pin_act_e               act_a, act_b;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= tmr_ctrl_t'(ctrl_wdata);
  end

  tmr_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (cnt_en),
    .cnt_o (cnt)
  );

  tmr_capture #(.SYNC(SYNC)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .pin      (cap_pin),
    .mode_en  (ctrl_q.cap_en),
    .edge_sel (ctrl_q.sel_b),
    .evt      (cap_evt)
  );

  assign cmp_gate[0] = 1'b1;
  assign cmp_gate[1] = ~ctrl_q.cap_en;

  generate
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      logic wr_i;
      assign wr_i = (i == 0) ? cmpa_wr : cmpb_wr;
      if (i == 1) begin : g_capreg
        always_ff @(posedge clk) begin
          if (rst)          cmp_q[i] <= '0;
          else if (cap_evt) cmp_q[i] <= cnt;
          else if (wr_i)    cmp_q[i] <= reg_wdata;
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (rst)       cmp_q[i] <= '0;
          else if (wr_i) cmp_q[i] <= reg_wdata;
        end
      end
      assign match[i] = cnt_en & cmp_gate[i] & (cnt == cmp_q[i]);
    end
  endgenerate

  assign act_a  = match[0] ? ctrl_q.sel_a : ACT_HOLD;
  assign act_b  = match[1] ? ctrl_q.sel_b : ACT_HOLD;
  assign out_en = (ctrl_q.sel_a != ACT_HOLD) || (ctrl_q.sel_b != ACT_HOLD);

  tmr_pin_ctl u_pin (
    .clk    (clk),
    .rst    (rst),
    .out_en (out_en),
    .act_a  (act_a),
    .act_b  (act_b),
    .pin_o  (tmr_out)
  );

  assign flag_set[FLG_A]   = match[0];
  assign flag_set[FLG_B]   = match[1];
  assign flag_set[FLG_CAP] = cap_evt;

  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)              flag_q[f] <= 1'b0;
        else if (flag_set[f]) flag_q[f] <= 1'b1;
        else if (flag_clr[f]) flag_q[f] <= 1'b0;
      end
    end
  endgenerate

  assign flags   = flag_q;
  assign count_o = cnt;
  assign regb_o  = cmp_q[1];

  AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (match[0] && !cmpa_wr) |=> !match[0]); // R2
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (regb_o == $past(cnt))); // R7
  AST_CAP_NO_BFLAG: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.cap_en && !flag_q[FLG_B]) |=> !flag_q[FLG_B]); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q[FLG_A] && !flag_clr[FLG_A]) |=> flag_q[FLG_A]); // R9
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    flag_set[FLG_CAP] |=> flag_q[FLG_CAP]); // R9
endmodule

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, cnt_en, cmpa_wr, cmpb_wr, ctrl_wr, cap_pin;
  logic [W-1:0] reg_wdata;
  logic [4:0]   ctrl_wdata;
  logic [2:0]   flag_clr;
  logic         tmr_out;
  logic [2:0]   flags;
  logic [W-1:0] count_o, regb_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_cmp_timer #(.W(W), .SYNC(2)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cmpa_wr(cmpa_wr), .cmpb_wr(cmpb_wr),
    .reg_wdata(reg_wdata), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .flag_clr(flag_clr), .cap_pin(cap_pin), .tmr_out(tmr_out), .flags(flags),
    .count_o(count_o), .regb_o(regb_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cnt_en = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0; ctrl_wr = 1'b0;
    reg_wdata = '0; ctrl_wdata = '0; flag_clr = '0; cap_pin = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic wr_a(input logic [W-1:0] v);
    reg_wdata = v; cmpa_wr = 1'b1; step(1); cmpa_wr = 1'b0;
  endtask

  task automatic wr_b(input logic [W-1:0] v);
    reg_wdata = v; cmpb_wr = 1'b1; step(1); cmpb_wr = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [1:0] sa, input logic [1:0] sb, input logic cap);
    ctrl_wdata = {cap, sb, sa}; ctrl_wr = 1'b1; step(1); ctrl_wr = 1'b0;
  endtask

  task automatic clr(input logic [2:0] m);
    flag_clr = m; step(1); flag_clr = '0;
  endtask

  task automatic wait_count(input logic [W-1:0] v);
    int n = 0;
    while (count_o !== v && n < 600) begin
      @(negedge clk);
      n++;
    end
    if (count_o !== v) chk("R1 wait_count", count_o, v);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R6 count", count_o, 0);
    chk("R6 pin", tmr_out, 0);
    chk("R6 flags", flags, 0);
    chk("R6 regb", regb_o, 0);
  endtask

  task automatic t_count();
    do_reset();
    cnt_en = 1'b1; step(3); cnt_en = 1'b0;
    chk("R1 increments", count_o, 3);
    step(2);
    chk("R1 holds", count_o, 3);
  endtask

  task automatic t_cmp_a();
    do_reset();
    wr_a(8'd5); wr_ctrl(2'b10, 2'b00, 1'b0); clr(3'b111);
    cnt_en = 1'b1;
    wait_count(8'd5); step(1);
    chk("R2 drive high", tmr_out, 1);
    chk("R9 flag A set", flags[0], 1);
    step(4);
    chk("R10 level held", tmr_out, 1);
    chk("R9 flag A sticky", flags[0], 1);
    clr(3'b001);
    chk("R9 flag A cleared", flags[0], 0);
    wr_a(8'd30); wr_ctrl(2'b01, 2'b00, 1'b0);
    wait_count(8'd30); step(1);
    chk("R2 drive low", tmr_out, 0);
    wr_a(8'd60); wr_ctrl(2'b11, 2'b00, 1'b0);
    wait_count(8'd60); step(1);
    chk("R2 toggle", tmr_out, 1);
    cnt_en = 1'b0;
  endtask

  task automatic t_cmp_b();
    do_reset();
    wr_a(8'd200); wr_b(8'd40); wr_ctrl(2'b00, 2'b10, 1'b0); clr(3'b111);
    cnt_en = 1'b1;
    wait_count(8'd40); step(1);
    chk("R3 B drive high", tmr_out, 1);
    chk("R3 flag B set", flags[1], 1);
    cnt_en = 1'b0;
  endtask

  task automatic t_prio();
    do_reset();
    wr_a(8'd50); wr_b(8'd50); wr_ctrl(2'b01, 2'b10, 1'b0);
    cnt_en = 1'b1;
    wait_count(8'd50); step(1);
    chk("R4 high over low", tmr_out, 1);
    wr_ctrl(2'b11, 2'b10, 1'b0);
    wait_count(8'd255); step(1);
    chk("R1 wrap to zero", count_o, 0);
    wait_count(8'd50); step(1);
    chk("R4 toggle over high", tmr_out, 0);
    wr_ctrl(2'b00, 2'b10, 1'b0);
    wait_count(8'd50); step(1);
    chk("R4 high over hold", tmr_out, 1);
    wr_ctrl(2'b01, 2'b00, 1'b0);
    wait_count(8'd50); step(1);
    chk("R4 low over hold", tmr_out, 0);
    cnt_en = 1'b0;
  endtask

  task automatic t_disable();
    do_reset();
    wr_a(8'd30); wr_ctrl(2'b10, 2'b00, 1'b0);
    cnt_en = 1'b1;
    wait_count(8'd30); step(1);
    chk("R5 pin high before disable", tmr_out, 1);
    wr_ctrl(2'b00, 2'b00, 1'b0); step(1);
    chk("R5 disabled pin low", tmr_out, 0);
    step(3);
    chk("R5 stays low", tmr_out, 0);
    cnt_en = 1'b0;
  endtask

  task automatic t_capture();
    logic [W-1:0] c1, c2, c3, c4;
    do_reset();
    cnt_en = 1'b1; step(7); cnt_en = 1'b0;
    c1 = count_o;
    wr_ctrl(2'b00, 2'b00, 1'b1); clr(3'b111);
    cap_pin = 1'b1; step(5);
    chk("R7 rising capture", regb_o, c1);
    chk("R7 capture flag", flags[2], 1);
    clr(3'b100);
    chk("R9 capture flag cleared", flags[2], 0);
    cnt_en = 1'b1; step(3); cnt_en = 1'b0;
    c2 = count_o;
    cap_pin = 1'b0; step(5);
    chk("R7 rising-only ignores fall", regb_o, c1);
    chk("R7 no flag on fall", flags[2], 0);
    wr_ctrl(2'b00, 2'b01, 1'b1);
    cap_pin = 1'b1; step(5);
    chk("R7 falling-only ignores rise", regb_o, c1);
    cap_pin = 1'b0; step(5);
    chk("R7 falling capture", regb_o, c2);
    wr_ctrl(2'b00, 2'b10, 1'b1);
    cnt_en = 1'b1; step(2); cnt_en = 1'b0;
    c3 = count_o;
    cap_pin = 1'b1; step(5);
    chk("R7 both edges rise", regb_o, c3);
    cnt_en = 1'b1; step(2); cnt_en = 1'b0;
    c4 = count_o;
    cap_pin = 1'b0; step(5);
    chk("R7 both edges fall", regb_o, c4);
  endtask

  task automatic t_cap_nomatch();
    do_reset();
    wr_a(8'd200); wr_b(8'd12); wr_ctrl(2'b00, 2'b10, 1'b1); clr(3'b111);
    cnt_en = 1'b1;
    wait_count(8'd12); step(2);
    cnt_en = 1'b0;
    chk("R8 no B flag in capture mode", flags[1], 0);
    chk("R8 pin untouched by B", tmr_out, 0);
    chk("R8 regb kept", regb_o, 12);
  endtask

  initial begin
    t_reset();
    t_count();
    t_cmp_a();
    t_cmp_b();
    t_prio();
    t_disable();
    t_capture();
    t_cap_nomatch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule